// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds a processor's stack pointer and turns the core's stack requests into SRAM accesses. The stack grows toward lower addresses. A one-byte push writes at the current pointer and then moves it down. A one-byte pop moves the pointer up and then reads. A call or interrupt entry stores a multi-byte return address (three bytes by default), one byte per cycle. A return reads those bytes back in reverse order. For each access the block drives the memory address, a write or read strobe, the outgoing data byte and a byte index that names which byte of the return address is moving.

Software sees the pointer as byte-wide halves, high and low, through a small I/O port. Reads are combinational. A write replaces one half on the next clock edge. If a write lands in the same cycle as a stack request, the write wins and the request is discarded. The pointer comes out of reset at the top of internal SRAM. A flag shows when the pointer has fallen into the reserved region at or below a set limit.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 0x20FF: high half 0x20, low half 0xFF. In the reset state `busy` is low, `sp_low` is low and neither memory strobe is active.
- R2: A byte push accepted while idle asserts `mem_we` for one cycle with `mem_addr` = pointer, `mem_wdata` = `push_data` and `byte_idx` = 0. The pointer then decreases by 1.
- R3: A byte pop accepted while idle asserts `mem_re` for one cycle with `mem_addr` = pointer + 1 and `byte_idx` = 0. The pointer then increases by 1.
- R4: A call stores `ret_addr` over three consecutive cycles. The first write puts bits 7:0 at the pointer P with `byte_idx` 0. The second puts bits 15:8 at P-1 with `byte_idx` 1. The third puts bits 23:16 at P-2 with `byte_idx` 2. The pointer ends at P-3.
- R5: A return reads over three consecutive cycles. The reads go to P+1 with `byte_idx` 2, then P+2 with `byte_idx` 1, then P+3 with `byte_idx` 0. The pointer ends at P+3.
- R6: `busy` is high in the cycles of a call or return that follow the request cycle, and goes low after the final byte. Requests presented while `busy` is high are ignored.
- R7: The I/O port selects the high half with `io_sel` = 1 and the low half with `io_sel` = 0. `io_rdata` shows the selected half combinationally. A write with `io_wr` loads `io_wdata` into the selected half on the next clock edge and leaves the other half unchanged.
- R8: When `io_wr` is high in an idle cycle, any stack request in that same cycle is discarded. No strobe is produced and the pointer takes only the software value.
- R9: `sp_low` is high exactly when the pointer is at or below 0x0100.
- R10: When several requests arrive together, the block serves exactly one of them. Call comes first, then return, then push, then pop.
- R11: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Push one data byte |
| pop_req | input | 1 | Pop one data byte |
| call_req | input | 1 | Store a return address (call or interrupt entry) |
| ret_req | input | 1 | Read back a return address |
| push_data | input | 8 | Byte to push |
| ret_addr | input | 24 | Return address to store |
| io_wr | input | 1 | Software write strobe |
| io_sel | input | 1 | Half select: 1 high, 0 low |
| io_wdata | input | 8 | Software write data |
| io_rdata | output | 8 | Selected half of the pointer |
| mem_addr | output | 16 | SRAM byte address |
| mem_we | output | 1 | SRAM write strobe |
| mem_re | output | 1 | SRAM read strobe |
| mem_wdata | output | 8 | SRAM write data |
| byte_idx | output | 2 | Which return-address byte is moving (0 for single-byte pushes and pops) |
| busy | output | 1 | Multi-byte sequence in progress |
| sp_low | output | 1 | Pointer at or below the reserved limit |

## Verification
The assertions check several properties on every cycle:
- the two strobes are exclusive;
- a software write in an idle cycle suppresses every strobe;
- each single step moves the pointer by exactly one;
- the byte index climbs by one through a call;
- `busy` drops right after the final byte.

Some behaviour only the bench's scenarios can show. These are the reset value, the exact addresses and data of each byte, the full three-byte ordering of call and return, and the low flag around the 0x0100 boundary. They also include the request priority and the discarding of requests while busy. The bench checks all of these against its own pointer model and a queue of expected memory transactions.

// File: rtl/stack_pkg.sv
package stack_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_CALL = 2'd1,
      SQ_RET  = 2'd2
   } seq_state_t;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/sp_reg.sv
module sp_reg #(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] RESET_SP = 16'h20FF,
   parameter int unsigned HSEL_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [HSEL_W-1:0] io_sel,
   input  logic [7:0]        io_wdata,
   input  logic              step_en,
   input  logic              step_dn,
   output logic [ADDR_W-1:0] sp,
   output logic [7:0]        io_rdata
);
   localparam int unsigned NUM_HALVES = ADDR_W / 8;

   logic [ADDR_W-1:0] sp_q;
   logic [ADDR_W-1:0] stepped;

   assign stepped = step_dn ? (sp_q - ADDR_W'(1)) : (sp_q + ADDR_W'(1));
   assign sp      = sp_q;

   for (genvar g = 0; g < NUM_HALVES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sp_q[g*8 +: 8] <= RESET_SP[g*8 +: 8];
         end else if (io_wr) begin
            if (io_sel == HSEL_W'(g)) begin
               sp_q[g*8 +: 8] <= io_wdata;
            end
         end else if (step_en) begin
            sp_q[g*8 +: 8] <= stepped[g*8 +: 8];
         end
      end
   end

   always_comb begin
      io_rdata = '0;
      for (int i = 0; i < NUM_HALVES; i++) begin
         if (io_sel == HSEL_W'(i)) begin
            io_rdata = sp_q[i*8 +: 8];
         end
      end
   end

   assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && step_dn && !io_wr) |=> (sp_q == $past(sp_q) - ADDR_W'(1)));

   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !step_dn && !io_wr) |=> (sp_q == $past(sp_q) + ADDR_W'(1)));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !io_wr) |=> $stable(sp_q));

endmodule

// File: rtl/sp_seq.sv
module sp_seq
   import stack_pkg::*;
#(
   parameter int unsigned RET_BYTES = 3,
   parameter int unsigned IDX_W     = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   io_wr,
   input  logic                   call_req,
   input  logic                   ret_req,
   input  logic                   push_req,
   input  logic                   pop_req,
   input  logic [7:0]             push_data,
   input  logic [RET_BYTES*8-1:0] ret_addr,
   output logic                   wr_en,
   output logic                   rd_en,
   output logic [IDX_W-1:0]       byte_idx,
   output logic [7:0]             wdata,
   output logic                   step_en,
   output logic                   step_dn,
   output logic                   busy
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(RET_BYTES - 1);

   seq_state_t             st_q, st_d;
   logic [IDX_W-1:0]       idx_q, idx_d;
   logic [RET_BYTES*8-1:0] ret_q;
   logic                   latch_ret;
   logic [7:0]             held_byte;

   always_comb begin
      held_byte = '0;
      for (int i = 0; i < RET_BYTES; i++) begin
         if (idx_q == IDX_W'(i)) begin
            held_byte = ret_q[i*8 +: 8];
         end
      end
   end

   always_comb begin
      st_d      = st_q;
      idx_d     = idx_q;
      wr_en     = 1'b0;
      rd_en     = 1'b0;
      byte_idx  = '0;
      wdata     = '0;
      step_en   = 1'b0;
      step_dn   = 1'b0;
      latch_ret = 1'b0;
      unique case (st_q)
         SQ_IDLE: begin
            if (!io_wr) begin
               if (call_req) begin
                  wr_en     = 1'b1;
                  wdata     = ret_addr[7:0];
                  step_en   = 1'b1;
                  step_dn   = 1'b1;
                  latch_ret = 1'b1;
                  st_d      = SQ_CALL;
                  idx_d     = IDX_W'(1);
               end else if (ret_req) begin
                  rd_en     = 1'b1;
                  byte_idx  = LAST;
                  step_en   = 1'b1;
                  st_d      = SQ_RET;
                  idx_d     = LAST - IDX_W'(1);
               end else if (push_req) begin
                  wr_en     = 1'b1;
                  wdata     = push_data;
                  step_en   = 1'b1;
                  step_dn   = 1'b1;
               end else if (pop_req) begin
                  rd_en     = 1'b1;
                  step_en   = 1'b1;
               end
            end
         end
         SQ_CALL: begin
            wr_en    = 1'b1;
            byte_idx = idx_q;
            wdata    = held_byte;
            step_en  = 1'b1;
            step_dn  = 1'b1;
            if (idx_q == LAST) begin
               st_d = SQ_IDLE;
            end else begin
               idx_d = idx_q + IDX_W'(1);
            end
         end
         SQ_RET: begin
            rd_en    = 1'b1;
            byte_idx = idx_q;
            step_en  = 1'b1;
            if (idx_q == '0) begin
               st_d = SQ_IDLE;
            end else begin
               idx_d = idx_q - IDX_W'(1);
            end
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         idx_q <= '0;
         ret_q <= '0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         if (latch_ret) begin
            ret_q <= ret_addr;
         end
      end
   end

   assign busy = (st_q != SQ_IDLE);

   assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (wr_en || rd_en) && ((wr_en && byte_idx == LAST) || (rd_en && byte_idx == '0)))
      |=> !busy);

   assert_call_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en) |-> (byte_idx == $past(byte_idx) + IDX_W'(1)));

   assert_ret_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_en) |-> (byte_idx == $past(byte_idx) - IDX_W'(1)));

endmodule

// File: rtl/sp_addr.sv
module sp_addr #(
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] LOW_LIMIT = 16'h0100
) (
   input  logic [ADDR_W-1:0] sp,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [7:0]        wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [7:0]        mem_wdata,
   output logic              sp_low
);
   assign mem_addr  = rd_en ? (sp + ADDR_W'(1)) : sp;
   assign mem_we    = wr_en;
   assign mem_re    = rd_en;
   assign mem_wdata = wr_en ? wdata : 8'h00;
   assign sp_low    = (sp <= LOW_LIMIT);

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       RET_BYTES = 3,
   parameter logic [ADDR_W-1:0] RESET_SP  = 16'h20FF,
   parameter logic [ADDR_W-1:0] LOW_LIMIT = 16'h0100,
   localparam int unsigned      HSEL_W    = (ADDR_W > 8) ? $clog2(ADDR_W / 8) : 1,
   localparam int unsigned      IDX_W     = (RET_BYTES > 1) ? $clog2(RET_BYTES) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   push_req,
   input  logic                   pop_req,
   input  logic                   call_req,
   input  logic                   ret_req,
   input  logic [7:0]             push_data,
   input  logic [RET_BYTES*8-1:0] ret_addr,
   input  logic                   io_wr,
   input  logic [HSEL_W-1:0]      io_sel,
   input  logic [7:0]             io_wdata,
   output logic [7:0]             io_rdata,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   mem_we,
   output logic                   mem_re,
   output logic [7:0]             mem_wdata,
   output logic [IDX_W-1:0]       byte_idx,
   output logic                   busy,
   output logic                   sp_low
);
   if ((ADDR_W % 8) != 0 || ADDR_W < 16) begin : g_bad_width
      $error("stack_ptr_unit: ADDR_W must be a multiple of 8 and at least 16");
   end
   if (RET_BYTES < 2) begin : g_bad_ret
      $error("stack_ptr_unit: RET_BYTES must be at least 2");
   end
   if ((1 << HSEL_W) != (ADDR_W / 8)) begin : g_bad_halves
      $error("stack_ptr_unit: ADDR_W/8 must be a power of two");
   end

   logic [ADDR_W-1:0] sp;
   logic              wr_en, rd_en, step_en, step_dn;
   logic [7:0]        seq_wdata;

   sp_reg #(
      .ADDR_W   (ADDR_W),
      .RESET_SP (RESET_SP),
      .HSEL_W   (HSEL_W)
   ) i_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_wr    (io_wr),
      .io_sel   (io_sel),
      .io_wdata (io_wdata),
      .step_en  (step_en),
      .step_dn  (step_dn),
      .sp       (sp),
      .io_rdata (io_rdata)
   );

   sp_seq #(
      .RET_BYTES (RET_BYTES),
      .IDX_W     (IDX_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_wr     (io_wr),
      .call_req  (call_req),
      .ret_req   (ret_req),
      .push_req  (push_req),
      .pop_req   (pop_req),
      .push_data (push_data),
      .ret_addr  (ret_addr),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .byte_idx  (byte_idx),
      .wdata     (seq_wdata),
      .step_en   (step_en),
      .step_dn   (step_dn),
      .busy      (busy)
   );

   sp_addr #(
      .ADDR_W    (ADDR_W),
      .LOW_LIMIT (LOW_LIMIT)
   ) i_addr (
      .sp        (sp),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .wdata     (seq_wdata),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .mem_wdata (mem_wdata),
      .sp_low    (sp_low)
   );

   assert_excl_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_io_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && io_wr) |-> !(mem_we || mem_re));

endmodule

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;

   typedef struct {
      logic        we;
      logic [15:0] addr;
      logic [7:0]  data;
      logic [1:0]  idx;
      string       tag;
   } xact_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_req = 1'b0, pop_req = 1'b0, call_req = 1'b0, ret_req = 1'b0;
   logic [7:0]  push_data = '0;
   logic [23:0] ret_addr = '0;
   logic        io_wr = 1'b0;
   logic [0:0]  io_sel = '0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [15:0] mem_addr;
   logic        mem_we, mem_re;
   logic [7:0]  mem_wdata;
   logic [1:0]  byte_idx;
   logic        busy, sp_low;

   int          n_vec = 0;
   int          n_bad = 0;
   bit          reported = 1'b0;
   logic [15:0] sp_m;
   xact_t       exp_q[$];

   always #4 clk = ~clk;

   stack_ptr_unit i_stack_ptr_unit (
      .clk(clk), .rst_n(rst_n),
      .push_req(push_req), .pop_req(pop_req), .call_req(call_req), .ret_req(ret_req),
      .push_data(push_data), .ret_addr(ret_addr),
      .io_wr(io_wr), .io_sel(io_sel), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
      .byte_idx(byte_idx), .busy(busy), .sp_low(sp_low)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   task automatic expect_x(input logic we, input logic [15:0] a, input logic [7:0] d,
                           input logic [1:0] ix, input string tag);
      xact_t t;
      t.we = we; t.addr = a; t.data = d; t.idx = ix; t.tag = tag;
      exp_q.push_back(t);
   endtask

   // monitor: compare each memory strobe against the scoreboard
   always @(negedge clk) begin
      if (rst_n && (mem_we || mem_re)) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected strobe addr", {16'h0, mem_addr}, 32'h0);
         end else begin
            xact_t t;
            t = exp_q.pop_front();
            check(mem_we == t.we && mem_re == !t.we, t.tag, "strobe kind",
                  {30'h0, mem_we, mem_re}, {30'h0, t.we, !t.we});
            check(!(mem_we && mem_re), "R11", "both strobes", {31'h0, mem_re}, 32'h0);
            check(mem_addr == t.addr, t.tag, "address", {16'h0, mem_addr}, {16'h0, t.addr});
            check(byte_idx == t.idx, t.tag, "byte_idx", {30'h0, byte_idx}, {30'h0, t.idx});
            if (t.we) begin
               check(mem_wdata == t.data, t.tag, "write data", {24'h0, mem_wdata}, {24'h0, t.data});
            end
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic check_sp(input string tag);
      io_sel = 1'b1;
      #1;
      check(io_rdata == sp_m[15:8], tag, "high half", {24'h0, io_rdata}, {24'h0, sp_m[15:8]});
      io_sel = 1'b0;
      #1;
      check(io_rdata == sp_m[7:0], tag, "low half", {24'h0, io_rdata}, {24'h0, sp_m[7:0]});
      check(sp_low == (sp_m <= 16'h0100), "R9", "sp_low", {31'h0, sp_low},
            {31'h0, (sp_m <= 16'h0100)});
   endtask

   task automatic do_push(input logic [7:0] d);
      expect_x(1'b1, sp_m, d, 2'd0, "R2");
      push_req = 1'b1; push_data = d;
      cyc();
      push_req = 1'b0;
      sp_m = sp_m - 16'd1;
   endtask

   task automatic do_pop();
      expect_x(1'b0, sp_m + 16'd1, 8'h00, 2'd0, "R3");
      pop_req = 1'b1;
      cyc();
      pop_req = 1'b0;
      sp_m = sp_m + 16'd1;
   endtask

   task automatic exp_call(input logic [23:0] a);
      expect_x(1'b1, sp_m,         a[7:0],   2'd0, "R4");
      expect_x(1'b1, sp_m - 16'd1, a[15:8],  2'd1, "R4");
      expect_x(1'b1, sp_m - 16'd2, a[23:16], 2'd2, "R4");
      sp_m = sp_m - 16'd3;
   endtask

   task automatic exp_ret();
      expect_x(1'b0, sp_m + 16'd1, 8'h00, 2'd2, "R5");
      expect_x(1'b0, sp_m + 16'd2, 8'h00, 2'd1, "R5");
      expect_x(1'b0, sp_m + 16'd3, 8'h00, 2'd0, "R5");
      sp_m = sp_m + 16'd3;
   endtask

   task automatic do_call(input logic [23:0] a);
      exp_call(a);
      call_req = 1'b1; ret_addr = a;
      cyc();
      call_req = 1'b0;
      check(busy == 1'b1, "R6", "busy step 2", {31'h0, busy}, 32'h1);
      cyc();
      check(busy == 1'b1, "R6", "busy step 3", {31'h0, busy}, 32'h1);
      cyc();
      check(busy == 1'b0, "R6", "busy after", {31'h0, busy}, 32'h0);
   endtask

   task automatic do_ret();
      exp_ret();
      ret_req = 1'b1;
      cyc();
      ret_req = 1'b0;
      check(busy == 1'b1, "R6", "busy ret", {31'h0, busy}, 32'h1);
      cyc();
      cyc();
      check(busy == 1'b0, "R6", "busy after ret", {31'h0, busy}, 32'h0);
   endtask

   task automatic io_write(input logic sel, input logic [7:0] d);
      io_wr = 1'b1; io_sel = sel; io_wdata = d;
      cyc();
      io_wr = 1'b0;
      if (sel) sp_m[15:8] = d; else sp_m[7:0] = d;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
      report();
   end

   initial begin
      sp_m = 16'h20FF;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1 reset state
      check_sp("R1");
      check(busy == 1'b0, "R1", "busy at reset", {31'h0, busy}, 32'h0);
      check(!mem_we && !mem_re, "R1", "strobe at reset", {30'h0, mem_we, mem_re}, 32'h0);

      // R2 / R3 single bytes
      do_push(8'hA5);
      check_sp("R2");
      do_pop();
      check_sp("R3");
      do_push(8'h11);
      do_push(8'h22);
      check_sp("R2");
      do_pop();
      do_pop();
      check_sp("R3");

      // R4 / R5 return address
      do_call(24'h123456);
      check_sp("R4");
      do_ret();
      check_sp("R5");

      // R6 requests during busy are ignored
      exp_call(24'hABCDEF);
      call_req = 1'b1; ret_addr = 24'hABCDEF;
      cyc();
      call_req = 1'b0; push_req = 1'b1; pop_req = 1'b1; ret_req = 1'b1;
      cyc();
      push_req = 1'b0; pop_req = 1'b0; ret_req = 1'b0;
      cyc();
      check_sp("R6");
      do_ret();
      check_sp("R6");

      // R10 priority: call beats push and pop, return beats push
      exp_call(24'h0F1E2D);
      call_req = 1'b1; push_req = 1'b1; pop_req = 1'b1; ret_addr = 24'h0F1E2D;
      push_data = 8'h77;
      cyc();
      call_req = 1'b0; push_req = 1'b0; pop_req = 1'b0;
      cyc();
      cyc();
      check_sp("R10");
      exp_ret();
      ret_req = 1'b1; push_req = 1'b1;
      cyc();
      ret_req = 1'b0; push_req = 1'b0;
      cyc();
      cyc();
      check_sp("R10");
      expect_x(1'b1, sp_m, 8'h3C, 2'd0, "R10");
      push_req = 1'b1; pop_req = 1'b1; push_data = 8'h3C;
      cyc();
      push_req = 1'b0; pop_req = 1'b0;
      sp_m = sp_m - 16'd1;
      check_sp("R10");
      do_pop();

      // R8 software write beats a push in the same cycle
      push_req = 1'b1; push_data = 8'h99;
      io_write(1'b1, 8'h01);
      push_req = 1'b0;
      check_sp("R8");
      // R7 low half write leaves high half
      io_write(1'b0, 8'h01);
      check_sp("R7");
      check(sp_m == 16'h0101, "R7", "model", {16'h0, sp_m}, 32'h0101);

      // R9 boundary around 0x0100
      do_push(8'h5A);
      check_sp("R9");
      check(sp_low == 1'b1, "R9", "at limit", {31'h0, sp_low}, 32'h1);
      do_push(8'h5B);
      check_sp("R9");
      do_pop();
      do_pop();
      check_sp("R9");
      check(sp_low == 1'b0, "R9", "above limit", {31'h0, sp_low}, 32'h0);

      repeat (3) cyc();
      check(exp_q.size() == 0, "R4", "missing transactions", exp_q.size(), 32'h0);
      report();
   end

endmodule